// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block is a read-only, direct-mapped cache placed between a requester and a slower word-addressed backing memory. The requester presents 32-bit byte addresses and receives 32-bit words. The cache stores 16 KB as 1024 lines of four 32-bit words. Each line has a stored tag and a valid bit.

Every accepted read is classified as a hit, a miss on an empty line, or a miss that evicts a line holding a different tag. A hit answers from the line store without touching memory. A miss reads the whole four-word line from memory one word at a time, installs the line, and then returns the requested word. Only one request is in flight at a time. The requester is held off until the response for the current request has been given.

Top module: `dm_read_cache`

## Requirements
- R1: The address is split as tag = bits [31:14], line index = bits [13:4], word select = bits [3:2]. Bits [1:0] are ignored, so any byte address inside a word returns that whole word.
- R2: While `rst` is high, and in the first cycle after it falls, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. Reset clears every valid bit, so the first read of any line after reset reports code 01.
- R3: A read whose indexed line is valid and whose stored tag equals the address tag reports code 00. It issues no memory read. Its response appears in the cycle right after the accepting clock edge.
- R4: A read whose indexed line is invalid reports code 01, fills the line and sets its valid bit. Code 11 is never produced.
- R5: A read whose indexed line is valid but holds another tag reports code 10. The old line and tag are overwritten, so a later read of the old tag at that index again reports code 10.
- R6: A fill issues exactly four memory reads, one at a time, at line base + 0x0, 0x4, 0x8 and 0xC in that order. Each read address is word-aligned and is held stable while `mem_req_ready` is low.
- R7: On a miss, the tag and valid bit are written only when the fourth word arrives. The response follows in the next cycle.
- R8: `rsp_data` always equals the backing-memory word at the address with bits [1:0] cleared, whether the read hit or missed.
- R9: `req_ready` is low from the cycle after an accept until the response cycle has ended. It is low whenever a memory read is requested. Each accepted request gets exactly one response.
- R10: `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned word |
| rsp_kind | output | 2 | Outcome code: 00 hit, 01 miss on empty line, 10 miss with eviction |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned memory read address |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The bound checker watches the handshake rules on every cycle. These cover: the ready drop after an accept, single-cycle response pulses, one-cycle hit latency, legal outcome codes, stable and aligned memory requests while stalled, a miss response only right after a memory word arrives, and quiet outputs after reset. Which outcome a given address sequence must produce, the correct returned word, and the exact order of fill addresses depend on the cache contents. Only the bench's scenarios can show these, including eviction at index 1 and at index 1023, ignored low address bits, fills under memory back-pressure, and valid bits cleared by a later reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    KIND_HIT   = 2'b00,
    KIND_COLD  = 2'b01,
    KIND_EVICT = 2'b10
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 1024,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_bits;
  logic [TAG_W-1:0] tag_mem [LINES];

  // valid bits live in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_bits <= '0;
      rd_valid   <= 1'b0;
    end else begin
      if (wr_en) valid_bits[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_bits[rd_idx];
    end
  end

  // tag array: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int LINES  = 1024,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] line_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_line;
    if (rd_en) rd_line <= line_mem[rd_idx];
  end
endmodule

// File: rtl/dmc_fill_ctrl.sv
module dmc_fill_ctrl
  import dmc_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int SEL_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             hit,
  input  logic             line_valid,
  output logic             in_look,
  output logic             in_done,
  output kind_e            kind_q,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  output logic [SEL_W-1:0] word_cnt,
  output logic             capture,
  output logic             install
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(LINE_WORDS - 1);

  state_e state;

  assign req_ready     = (state == ST_IDLE);
  assign in_look       = (state == ST_LOOK);
  assign in_done       = (state == ST_DONE);
  assign mem_req_valid = (state == ST_REQ);
  assign capture       = (state == ST_WAIT) && mem_rsp_valid;
  assign install       = capture && (word_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      word_cnt <= '0;
      kind_q   <= KIND_HIT;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) state <= ST_LOOK;
        ST_LOOK: begin
          if (hit) begin
            state <= ST_IDLE;
          end else begin
            state    <= ST_REQ;
            word_cnt <= '0;
            kind_q   <= line_valid ? KIND_EVICT : KIND_COLD;
          end
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (word_cnt == LAST) begin
              state <= ST_DONE;
            end else begin
              word_cnt <= word_cnt + 1'b1;
              state    <= ST_REQ;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 1024,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int SEL_W  = $clog2(LINE_WORDS);
  localparam int OFF_W  = BOFF_W + SEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;

  // address fields
  logic [IDX_W-1:0] in_idx;
  logic [TAG_W-1:0] q_tag;
  logic [IDX_W-1:0] q_idx;
  logic [SEL_W-1:0] q_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [BOFF_W-1:0] unused_byte_bits;

  assign in_idx           = req_addr[OFF_W +: IDX_W];
  assign q_tag            = addr_q[ADDR_W-1 -: TAG_W];
  assign q_idx            = addr_q[OFF_W +: IDX_W];
  assign q_sel            = addr_q[BOFF_W +: SEL_W];
  assign unused_byte_bits = addr_q[BOFF_W-1:0];

  logic accept;
  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  // controller
  logic             in_look, in_done, capture, install, hit, line_valid;
  logic [SEL_W-1:0] word_cnt;
  kind_e            kind_q;
  logic [TAG_W-1:0] stored_tag;

  dmc_fill_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .hit          (hit),
    .line_valid   (line_valid),
    .in_look      (in_look),
    .in_done      (in_done),
    .kind_q       (kind_q),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .word_cnt     (word_cnt),
    .capture      (capture),
    .install      (install)
  );

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (accept),
    .rd_idx  (in_idx),
    .rd_valid(line_valid),
    .rd_tag  (stored_tag),
    .wr_en   (install),
    .wr_idx  (q_idx),
    .wr_tag  (q_tag)
  );

  assign hit = line_valid && (stored_tag == q_tag);

  // line assembly
  logic [WORD_W-1:0] fill_buf [LINE_WORDS];
  logic [LINE_W-1:0] new_line;
  logic [LINE_W-1:0] cur_line;
  logic [WORD_W-1:0] cur_words [LINE_WORDS];

  always_ff @(posedge clk) begin
    if (capture) fill_buf[word_cnt] <= mem_rsp_data;
  end

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_words
    if (g == LINE_WORDS - 1) begin : g_last
      assign new_line[g*WORD_W +: WORD_W] = mem_rsp_data;
    end else begin : g_early
      assign new_line[g*WORD_W +: WORD_W] = fill_buf[g];
    end
    assign cur_words[g] = cur_line[g*WORD_W +: WORD_W];
  end

  dmc_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
    .clk    (clk),
    .rd_en  (accept),
    .rd_idx (in_idx),
    .rd_line(cur_line),
    .wr_en  (install),
    .wr_idx (q_idx),
    .wr_line(new_line)
  );

  // response and memory request
  assign rsp_valid    = (in_look && hit) || in_done;
  assign rsp_data     = in_look ? cur_words[q_sel] : fill_buf[q_sel];
  assign rsp_kind     = in_look ? KIND_HIT : kind_q;
  assign mem_req_addr = {q_tag, q_idx, word_cnt, {BOFF_W{1'b0}}};
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  assert_quiet_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !mem_req_valid && req_ready));

  assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'b00) |-> $past(req_valid && req_ready));

  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_kind != 2'b11));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_req_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_miss_after_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != 2'b00) |-> $past(mem_rsp_valid));

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_busy_while_fill_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind dm_read_cache dmc_checker #(.ADDR_W(ADDR_W)) u_dmc_checker (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_kind     (rsp_kind),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_dm_read_cache.sv
module test_dm_read_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_kind;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit stall_mode = 1'b0;
  int mem_cnt = 0;
  logic [31:0] mem_log [16];

  always #4 clk = ~clk;

  dm_read_cache i_dm_read_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return {w[15:0], w[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  // backing memory: one-cycle latency, optional alternating back-pressure
  initial begin
    forever begin
      @(posedge clk);
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_val(mem_req_addr);
        if (mem_cnt < 16) mem_log[mem_cnt] = mem_req_addr;
        mem_cnt = mem_cnt + 1;
      end else begin
        mem_rsp_valid <= 1'b0;
      end
      mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [1:0] exp_kind);
    int cyc;
    logic [31:0] base;
    base = {a[31:4], 4'h0};
    @(negedge clk);
    mem_cnt = 0;
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    check(!req_ready, "R9", "ready low after accept", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    check(rsp_valid, "R9", "response seen", {31'd0, rsp_valid}, 32'd1);
    check(rsp_kind == exp_kind, (exp_kind == 2'b00) ? "R3" :
          (exp_kind == 2'b01) ? "R4" : "R5", "outcome code",
          {30'd0, rsp_kind}, {30'd0, exp_kind});
    check(rsp_data == mem_val(a), "R8", "returned word", rsp_data, mem_val(a));
    if (exp_kind == 2'b00) begin
      check(cyc == 1, "R3", "hit latency", cyc, 32'd1);
      check(mem_cnt == 0, "R3", "hit memory reads", mem_cnt, 32'd0);
    end else begin
      check(mem_cnt == 4, "R6", "fill read count", mem_cnt, 32'd4);
      for (int k = 0; k < 4; k++)
        check(mem_log[k] == base + 32'(4 * k), "R6", "fill address order",
              mem_log[k], base + 32'(4 * k));
    end
    @(negedge clk);
    check(!rsp_valid, "R10", "single-cycle response", {31'd0, rsp_valid}, 32'd0);
    check(req_ready, "R9", "ready back after response", {31'd0, req_ready}, 32'd1);
  endtask

  // {address, expected outcome}: 00 hit, 01 empty-line miss, 10 eviction
  localparam int NVEC = 14;
  localparam logic [33:0] VEC [NVEC] = '{
    {32'h0000_0014, 2'b01},  // R4 cold miss, index 1
    {32'h0000_001C, 2'b00},  // R3 same line hit
    {32'h0000_0034, 2'b01},  // R4 index 3
    {32'h0000_8014, 2'b10},  // R5 index 1, tag 0 replaced by tag 2
    {32'h0000_0030, 2'b00},  // R3 index 3 still present
    {32'h0000_001C, 2'b10},  // R5 old tag 0 back at index 1
    {32'h0000_0017, 2'b00},  // R1 low two bits ignored, word at 0x14
    {32'h0000_3FF0, 2'b01},  // R4 top index 1023
    {32'h0000_3FFC, 2'b00},  // R3 last word of the line
    {32'hFFFF_FFF8, 2'b10},  // R5 all-ones tag evicts index 1023
    {32'hFFFF_FFF0, 2'b00},  // R3
    {32'h0000_0000, 2'b01},  // R4 index 0
    {32'h0000_8014, 2'b10},  // R5
    {32'h0000_4010, 2'b10}   // R1 tag 1 at index 1
  };

  initial begin
    repeat (3) @(negedge clk);
    // R2 outputs during reset
    check(req_ready, "R2", "ready in reset", {31'd0, req_ready}, 32'd1);
    check(!rsp_valid, "R2", "no response in reset", {31'd0, rsp_valid}, 32'd0);
    check(!mem_req_valid, "R2", "no memory read in reset", {31'd0, mem_req_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) do_read(VEC[i][33:2], VEC[i][1:0]);

    // R6 fills under memory back-pressure
    stall_mode = 1'b1;
    do_read(32'h0000_5008, 2'b01);
    do_read(32'h0000_9004, 2'b10);
    do_read(32'h0000_900C, 2'b00);
    stall_mode = 1'b0;
    repeat (2) @(negedge clk);

    // R2 reset clears valid bits: previously hit lines now miss as empty
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    do_read(32'h0000_0030, 2'b01);
    do_read(32'h0000_9000, 2'b01);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule